// File: doc/BRIEF.md
# Timing Mode Controller and Alarm Aggregator

This block sits beside a clock-synchronisation loop and picks what that loop does. Two external select lines name one of four operating states: free run, locked to reference 1, locked to reference 2, or holdover. The block registers the chosen state and drives a one-hot indicator for it. It also drives a select bit for the reference multiplexer in front of the loop. A combined alarm output merges two kinds of condition. The first is the unlocked states, which are free run and holdover. The second is three fault flags that the loop reports: loss of lock, loss of reference and tuning-range limit.

The select lines come from slow, asynchronous logic. They first pass through a synchroniser. A new code is accepted only after it has stayed unchanged for a window counted in ticks of an external timebase of one tick per millisecond. Because of this, an indicator moves more than 2 ms and less than 4.125 ms after the select change. A shorter excursion on the select lines is discarded.

A high-impedance request floats the indicator and alarm outputs so that a redundant partner module can drive a shared bus. The reference select bit is unaffected by that request, because it feeds logic inside the same device.

Top module: `tmode_ctrl`

## Requirements
- R1: After reset, and whenever the accepted select code {A,B} is 00, the block is in free run: `ind_free_o`=1 and the other three indicators are 0. Reset also forces `alarm_o`=1 and `tvl_alarm_o`=0.
- R2: The accepted code {A,B} decodes as follows: 10 gives reference 1 (`ind_ref1_o`), 01 gives reference 2 (`ind_ref2_o`) and 11 gives holdover (`ind_hold_o`).
- R3: Exactly one of the four indicators is high at all times while the outputs are driven.
- R4: `alarm_o` is 1 in free run and in holdover, whatever the fault flags are.
- R5: In a reference state, `alarm_o` is 1 exactly when at least one of `lol_i`, `lor_i` or `tvl_i` is high. Each flag reaches the alarm within 3 clock cycles.
- R6: `tvl_alarm_o` is 1 only when `tvl_i` is high in a reference state. Loss of lock or loss of reference alone leaves it at 0, and it is 0 in free run and holdover.
- R7: With one tick per millisecond, an indicator change follows a stable select change by more than 2 and fewer than 4.125 tick periods.
- R8: A select code that reverts before it has been stable for `SETTLE_TICKS` ticks is ignored: the indicators never show it.
- R9: While `tri_req_i`=1, the four indicators, `alarm_o` and `tvl_alarm_o` are high impedance. With `tri_req_i`=0 they are driven normally.
- R10: `ref_sel_o` is 0 in reference 1 and 1 in reference 2. In holdover and free run it keeps its last value. Reset sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a_i | input | 1 | Mode select line A (asynchronous) |
| sel_b_i | input | 1 | Mode select line B (asynchronous) |
| lol_i | input | 1 | Loss-of-lock flag from the loop (asynchronous) |
| lor_i | input | 1 | Loss-of-reference flag (asynchronous) |
| tvl_i | input | 1 | Tuning-range-limit flag (asynchronous) |
| tri_req_i | input | 1 | 1 floats the status outputs |
| tick_i | input | 1 | One-clock timebase pulse, nominally 1 kHz |
| ind_hold_o | output | 1 | Holdover indicator |
| ind_ref1_o | output | 1 | Reference 1 indicator |
| ind_ref2_o | output | 1 | Reference 2 indicator |
| ind_free_o | output | 1 | Free-run indicator |
| alarm_o | output | 1 | Combined alarm |
| tvl_alarm_o | output | 1 | Tuning-limit alarm |
| ref_sel_o | output | 1 | Reference multiplexer select |

## Verification
Some properties are checked by assertions on every cycle. The one-hot indicator state is one. The alarm is asserted in unlocked states and after any fault flag has had time to propagate. The tuning-limit alarm implies both a reference state and the alarm. Indicators change only in the cycle set by a preceding tick. The multiplexer select is held steady through unlocked states. Other behaviour needs the bench's scenarios to show it. The scenarios measure the settle window against the 2 ms and 4.125 ms bounds. They confirm that a short select excursion is dropped. They show that the high-impedance state appears on the pins. They show that the select bit recalls the last reference after holdover and free run.

// File: rtl/tmode_pkg.sv
// Shared types for the timing mode controller.
// Assumes the select code is {A,B}; the enum values equal that code.
package tmode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_REF2 = 2'b01,
        MODE_REF1 = 2'b10,
        MODE_HOLD = 2'b11
    } mode_t;

    localparam int IND_HOLD = 0;
    localparam int IND_REF1 = 1;
    localparam int IND_REF2 = 2;
    localparam int IND_FREE = 3;
    localparam int IND_W    = 4;

    // One-hot indicator pattern for a mode.
    function automatic logic [IND_W-1:0] mode_to_ind(mode_t m);
        logic [IND_W-1:0] v;
        v = '0;
        case (m)
            MODE_HOLD: v[IND_HOLD] = 1'b1;
            MODE_REF1: v[IND_REF1] = 1'b1;
            MODE_REF2: v[IND_REF2] = 1'b1;
            default:   v[IND_FREE] = 1'b1;
        endcase
        return v;
    endfunction

    // True for the two locked (reference) modes.
    function automatic logic is_ref(mode_t m);
        return (m == MODE_REF1) || (m == MODE_REF2);
    endfunction

endpackage

// File: rtl/tmode_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous levels.
// Assumes each bit is a slow level; no multi-bit coherence is promised.
module tmode_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tmode_settle.sv
// Accepts a synchronised select code only after it has stayed unchanged
// for SETTLE_TICKS timebase ticks. Assumes tick_i is a one-cycle pulse.
module tmode_settle
    import tmode_pkg::*;
#(
    parameter int SETTLE_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_i,
    input  logic       tick_i,
    output mode_t      mode_o
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

    logic [1:0]       cand_q;
    logic [CNT_W-1:0] cnt_q;
    mode_t            mode_q;

    // Track the candidate code and count ticks of stability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= MODE_FREE;
            cnt_q  <= '0;
            mode_q <= MODE_FREE;
        end else if (code_i != cand_q) begin
            cand_q <= code_i;
            cnt_q  <= '0;
        end else if (cand_q != mode_q && tick_i) begin
            if (cnt_q == LAST) begin
                mode_q <= mode_t'(cand_q);
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/tmode_status.sv
// Registers the indicators, merges the alarm sources and keeps the
// reference multiplexer select. Assumes fault flags are synchronised.
module tmode_status
    import tmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_i,
    input  logic             lol_i,
    input  logic             lor_i,
    input  logic             tvl_i,
    output logic [IND_W-1:0] ind_o,
    output logic             alarm_o,
    output logic             tvl_alarm_o,
    output logic             ref_sel_o
);
    logic locked;
    logic fault;

    // Classify the current mode and fault set.
    always_comb begin
        locked = is_ref(mode_i);
        fault  = lol_i | lor_i | tvl_i;
    end

    // Register the indicator pattern and both alarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_o       <= mode_to_ind(MODE_FREE);
            alarm_o     <= 1'b1;
            tvl_alarm_o <= 1'b0;
        end else begin
            ind_o       <= mode_to_ind(mode_i);
            alarm_o     <= !locked || fault;
            tvl_alarm_o <= locked && tvl_i;
        end
    end

    // Update the multiplexer select only in a reference mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sel_o <= 1'b0;
        end else if (mode_i == MODE_REF1) begin
            ref_sel_o <= 1'b0;
        end else if (mode_i == MODE_REF2) begin
            ref_sel_o <= 1'b1;
        end
    end
endmodule

// File: rtl/tmode_ctrl.sv
// Top of the timing mode controller: synchronises the select and fault
// inputs, settles the mode, registers the status and floats the status
// pins on request. Assumes tick_i pulses once per millisecond.
module tmode_ctrl
    import tmode_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_a_i,
    input  logic sel_b_i,
    input  logic lol_i,
    input  logic lor_i,
    input  logic tvl_i,
    input  logic tri_req_i,
    input  logic tick_i,
    output logic ind_hold_o,
    output logic ind_ref1_o,
    output logic ind_ref2_o,
    output logic ind_free_o,
    output logic alarm_o,
    output logic tvl_alarm_o,
    output logic ref_sel_o
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;
    mode_t            mode_acc;
    logic [IND_W-1:0] ind_q;
    logic             alarm_q;
    logic             tvl_q;
    logic             ref_sel_q;

    assign raw_in = {sel_a_i, sel_b_i, lol_i, lor_i, tvl_i};

    tmode_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    tmode_settle #(.SETTLE_TICKS(SETTLE_TICKS)) settle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (syn[4:3]),
        .tick_i (tick_i),
        .mode_o (mode_acc)
    );

    tmode_status status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_acc),
        .lol_i       (syn[2]),
        .lor_i       (syn[1]),
        .tvl_i       (syn[0]),
        .ind_o       (ind_q),
        .alarm_o     (alarm_q),
        .tvl_alarm_o (tvl_q),
        .ref_sel_o   (ref_sel_q)
    );

    // Float the status pins when the partner module takes the bus.
    assign ind_hold_o  = tri_req_i ? 1'bz : ind_q[IND_HOLD];
    assign ind_ref1_o  = tri_req_i ? 1'bz : ind_q[IND_REF1];
    assign ind_ref2_o  = tri_req_i ? 1'bz : ind_q[IND_REF2];
    assign ind_free_o  = tri_req_i ? 1'bz : ind_q[IND_FREE];
    assign alarm_o     = tri_req_i ? 1'bz : alarm_q;
    assign tvl_alarm_o = tri_req_i ? 1'bz : tvl_q;
    assign ref_sel_o   = ref_sel_q;
endmodule

// File: rtl/tmode_ctrl_chk.sv
// Cycle-by-cycle properties of the timing mode controller, bound to the top.
// Assumes the default two-stage synchroniser for the fault-latency checks.
module tmode_ctrl_chk
    import tmode_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [IND_W-1:0] ind,
    input logic             alarm,
    input logic             tvl,
    input logic             ref_sel,
    input logic             tick,
    input logic             lol,
    input logic             lor
);
    a_r3_one_indicator: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ind) == 1);

    a_r4_unlocked_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (ind[IND_FREE] || ind[IND_HOLD]) |-> alarm);

    a_r5_lol_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lol, 3) && $past(lol, 2) && $past(rst_n, 3)) |-> alarm);

    a_r5_lor_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lor, 3) && $past(lor, 2) && $past(rst_n, 3)) |-> alarm);

    a_r6_tvl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        tvl |-> (alarm && (ind[IND_REF1] || ind[IND_REF2])));

    a_r7_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ind) && $past(rst_n)) |-> $past(tick, 2));

    a_r10_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((ind[IND_FREE] || ind[IND_HOLD]) &&
         ($past(ind[IND_FREE]) || $past(ind[IND_HOLD]))) |-> $stable(ref_sel));
endmodule

bind tmode_ctrl tmode_ctrl_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ind     (ind_q),
    .alarm   (alarm_q),
    .tvl     (tvl_q),
    .ref_sel (ref_sel_q),
    .tick    (tick_i),
    .lol     (lol_i),
    .lor     (lor_i)
);

// File: tb/tmode_ctrl_tb_top.sv
// Directed bench for the timing mode controller.
module tmode_ctrl_tb_top;
    localparam int P = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0;
    logic lol = 1'b0, lor = 1'b0, tvl = 1'b0;
    logic tri_req = 1'b0;
    logic tick = 1'b0;
    logic ind_hold, ind_ref1, ind_ref2, ind_free, alarm, tvl_alarm, ref_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmode_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .sel_a_i (sel_a), .sel_b_i (sel_b),
        .lol_i (lol), .lor_i (lor), .tvl_i (tvl), .tri_req_i (tri_req),
        .tick_i (tick), .ind_hold_o (ind_hold), .ind_ref1_o (ind_ref1),
        .ind_ref2_o (ind_ref2), .ind_free_o (ind_free), .alarm_o (alarm),
        .tvl_alarm_o (tvl_alarm), .ref_sel_o (ref_sel)
    );

    // Millisecond timebase: one pulse every P clocks.
    initial begin
        forever begin
            repeat (P - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status();
        return {1'b0, ind_free, ind_ref1, ind_ref2, ind_hold, alarm, tvl_alarm, ref_sel};
    endfunction

    // Pattern {0,free,ref1,ref2,hold,alarm,tvl,sel}.
    function automatic logic [7:0] pat(logic [3:0] ind, logic al, logic tv, logic rs);
        return {1'b0, ind, al, tv, rs};
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(logic a, logic b);
        sel_a = a;
        sel_b = b;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_clk(4);
        check("R1 reset state", status(), pat(4'b1000, 1'b1, 1'b0, 1'b0));
        rst_n = 1'b1;
        wait_clk(5 * P);
        check("R1 free run with code 00", status(), pat(4'b1000, 1'b1, 1'b0, 1'b0));
    endtask

    task automatic t_decode();
        set_code(1'b1, 1'b0);
        wait_clk(5 * P);
        check("R2 code 10 gives reference 1", status(), pat(4'b0100, 1'b0, 1'b0, 1'b0));
        set_code(1'b0, 1'b1);
        wait_clk(5 * P);
        check("R2 code 01 gives reference 2", status(), pat(4'b0010, 1'b0, 1'b0, 1'b1));
        set_code(1'b1, 1'b1);
        wait_clk(5 * P);
        check("R2 R10 code 11 holdover keeps select", status(), pat(4'b0001, 1'b1, 1'b0, 1'b1));
        set_code(1'b0, 1'b0);
        wait_clk(5 * P);
        check("R1 R4 back to free run", status(), pat(4'b1000, 1'b1, 1'b0, 1'b1));
        set_code(1'b1, 1'b0);
        wait_clk(5 * P);
        check("R10 reference 1 clears select", status(), pat(4'b0100, 1'b0, 1'b0, 1'b0));
        set_code(1'b0, 1'b0);
        wait_clk(5 * P);
        check("R10 free run keeps select 0", ref_sel, 1'b0);
    endtask

    task automatic t_timing();
        set_code(1'b0, 1'b1);
        wait_clk(2 * P);
        check("R7 no change at 2 ms", status(), pat(4'b1000, 1'b1, 1'b0, 1'b0));
        wait_clk(2 * P);
        check("R7 changed before 4.125 ms", status(), pat(4'b0010, 1'b0, 1'b0, 1'b1));
        check("R3 one indicator", 8'($countones({ind_free, ind_ref1, ind_ref2, ind_hold})), 8'd1);
    endtask

    task automatic t_glitch();
        set_code(1'b1, 1'b1);
        wait_clk(P);
        set_code(1'b0, 1'b1);
        for (int i = 0; i < 6 * P; i++) begin
            @(negedge clk);
            if (ind_hold !== 1'b0 || ind_ref2 !== 1'b1) begin
                check("R8 short code ignored", {ind_hold, ind_ref2}, 8'b01);
                break;
            end
        end
        check("R8 still reference 2", status(), pat(4'b0010, 1'b0, 1'b0, 1'b1));
    endtask

    task automatic t_faults();
        lor = 1'b1;
        wait_clk(4);
        check("R5 R6 loss of reference", status(), pat(4'b0010, 1'b1, 1'b0, 1'b1));
        lor = 1'b0;
        lol = 1'b1;
        wait_clk(4);
        check("R5 R6 loss of lock", status(), pat(4'b0010, 1'b1, 1'b0, 1'b1));
        lol = 1'b0;
        wait_clk(4);
        check("R5 faults cleared", status(), pat(4'b0010, 1'b0, 1'b0, 1'b1));
        tvl = 1'b1;
        wait_clk(4);
        check("R5 R6 tuning limit in reference", status(), pat(4'b0010, 1'b1, 1'b1, 1'b1));
        set_code(1'b1, 1'b1);
        wait_clk(5 * P);
        check("R6 tuning limit in holdover", status(), pat(4'b0001, 1'b1, 1'b0, 1'b1));
        tvl = 1'b0;
        wait_clk(4);
        check("R4 holdover alarm without faults", alarm, 1'b1);
    endtask

    task automatic t_tristate();
        tri_req = 1'b1;
        #1;
        check("R9 outputs float", {2'b00, ind_free, ind_ref1, ind_ref2, ind_hold, alarm, tvl_alarm},
              {2'b00, 6'bzzzzzz});
        check("R9 select stays driven", ref_sel, 1'b1);
        tri_req = 1'b0;
        #1;
        check("R9 outputs restored", status(), pat(4'b0001, 1'b1, 1'b0, 1'b1));
    endtask

    task automatic finish_report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_timing();
        t_glitch();
        t_faults();
        t_tristate();
        finish_report();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_report();
    end
endmodule